// File: doc/BRIEF.md
# Hybrid Variable-Stage Carry-Skip Adder

A purely combinational 32-bit binary adder. It takes two operands and a carry-in, and it returns a 32-bit sum and a carry-out. The operand width is cut into five stages of unequal size. Counted from the least significant end, they are 3, 5, 16, 5 and 3 bits wide. The short stages sit at both ends, so the carry reaches the wide middle stage early and leaves the last stage quickly.

The lowest stage is a plain ripple chain that uses the real carry-in. The three other outer stages each work in two steps. First, a ripple chain adds the slice as if its carry-in were zero. Then a half-adder chain folds the real incoming carry into that partial sum. The 16-bit middle stage is a log-depth parallel-prefix adder.

Each stage's outgoing carry is formed by a compound gate: its local generate OR (the AND of all stage propagate bits AND the incoming carry). The gate alternates between AND-OR-invert and OR-AND-invert polarity from stage to stage; no multiplexer is used. Every ripple cell uses shared logic steered by its carry. With carry 0 it gives XOR for the sum and AND for the carry. With carry 1 it gives XNOR for the sum and OR for the carry.

Top module: `hvs_skip_adder`

## Requirements
- R1: `{cout_o, sum_o}` equals the 33-bit value `a_i + b_i + cin_i` for every input combination.
- R2: The stages occupy bit ranges [2:0], [7:3], [23:8], [28:24] and [31:29]. A carry produced inside one stage arrives correctly in all higher stages.
- R3: The lowest stage consumes `cin_i` directly, so `0 + 0 + 1` gives sum 1 and carry-out 0.
- R4: When every bit of a stage propagates (a XOR b all ones), the stage's outgoing carry equals its incoming carry. A carry-in of 1 with all 32 bits propagating gives sum 0 and carry-out 1.
- R5: In a ripple-plus-increment stage whose zero-carry partial sum is all ones, an incoming carry of 1 clears that slice and passes a carry onward.
- R6: The 16-bit middle stage adds its slice correctly both for carries generated inside it and for a carry entering it from below.
- R7: `cout_o` is the carry leaving the top stage (bits 31:29). `FFFFFFFF + FFFFFFFF + 1` gives sum `FFFFFFFF` and carry-out 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | 32 | Sum bits |
| cout_o | output | 1 | Carry out of bit 31 |

## Verification
The block holds no state, so a wrong internal carry shows up at the ports on the same evaluation as the input change. It appears as a sum wrong from the first bit of the affected stage upward, or as a wrong carry-out.

A broken skip gate only shows when an entire stage propagates. The directed vectors therefore include full-width and single-stage propagate chains, alongside random operands. A defect in the prefix tree or in an increment chain typically corrupts only a few sum bits, which the bit-exact sum comparison catches.

// File: rtl/hvs_skip_adder.sv
module hvs_skip_adder #(
  parameter int W0 = 3,
  parameter int W1 = 5,
  parameter int WN = 16,
  parameter int W3 = 5,
  parameter int W4 = 3,
  localparam int W = W0 + W1 + WN + W3 + W4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  localparam int NS = 5;
  localparam int WID [NS] = '{W0, W1, WN, W3, W4};
  localparam int OFF [NS] = '{0, W0, W0 + W1, W0 + W1 + WN, W0 + W1 + WN + W3};

  logic [NS:0]   cy;
  logic [NS-1:0] sp, sg;

  assign cy[0]  = cin_i;
  assign cout_o = cy[NS];

  for (genvar s = 0; s < NS; s++) begin : g_stg
    localparam int LO = OFF[s];
    localparam int WD = WID[s];
    logic [WD-1:0] as, bs, xs;
    logic          gl, pl;
    assign as = a_i[LO +: WD];
    assign bs = b_i[LO +: WD];
    assign xs = as ^ bs;
    assign sp[s] = &xs;

    if (s == 0) begin : g_rip
      logic [WD:0] c;
      assign c[0] = cy[s];
      for (genvar i = 0; i < WD; i++) begin : g_fa
        assign c[i+1]       = c[i] ? (as[i] | bs[i]) : (as[i] & bs[i]);
        assign sum_o[LO+i]  = c[i] ? ~xs[i] : xs[i];
      end
      assign gl    = 1'b0;
      assign pl    = 1'b0;
      assign sg[s] = 1'b0;
      assign cy[s+1] = c[WD] | (gl & pl);
    end else if (s == 2) begin : g_pfx
      localparam int LV = $clog2(WD);
      logic [LV:0][WD-1:0] gg, pp;
      logic [WD-1:0]       ci;
      assign gg[0] = as & bs;
      assign pp[0] = xs;
      for (genvar l = 0; l < LV; l++) begin : g_lvl
        for (genvar i = 0; i < WD; i++) begin : g_cell
          if (i >= (1 << l)) begin : g_bk
            assign gg[l+1][i] = gg[l][i] | (pp[l][i] & gg[l][i-(1<<l)]);
            assign pp[l+1][i] = pp[l][i] & pp[l][i-(1<<l)];
          end else begin : g_pass
            assign gg[l+1][i] = gg[l][i];
            assign pp[l+1][i] = pp[l][i];
          end
        end
      end
      assign ci[0] = cy[s];
      for (genvar i = 1; i < WD; i++) begin : g_ci
        assign ci[i] = gg[LV][i-1] | (pp[LV][i-1] & cy[s]);
      end
      assign sum_o[LO +: WD] = xs ^ ci;
      assign gl    = gg[LV][WD-1];
      assign pl    = pp[LV][WD-1];
      assign sg[s] = gl;
    end else begin : g_inc
      logic [WD:0]   z;
      logic [WD-1:0] ps, t;
      assign z[0] = 1'b0;
      assign t[0] = cy[s];
      for (genvar i = 0; i < WD; i++) begin : g_fa
        assign z[i+1]      = z[i] ? (as[i] | bs[i]) : (as[i] & bs[i]);
        assign ps[i]       = z[i] ? ~xs[i] : xs[i];
        assign sum_o[LO+i] = ps[i] ^ t[i];
        if (i < WD - 1) begin : g_ha
          assign t[i+1] = ps[i] & t[i];
        end
      end
      assign gl    = z[WD];
      assign pl    = sp[s];
      assign sg[s] = gl;
    end

    if (s != 0) begin : g_skip
      if (s % 2 == 1) begin : g_aoi
        logic nco;
        assign nco     = ~(gl | (pl & cy[s]));
        assign cy[s+1] = ~nco;
      end else begin : g_oai
        assign cy[s+1] = ~(~gl & (~pl | ~cy[s]));
      end
    end
  end

  logic [W:0] ref_w;
  assign ref_w = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};

  always_comb begin
    a_r1_sum_matches: assert ({cout_o, sum_o} == ref_w)
      else $error("R1 sum mismatch");
    a_r7_cout_top: assert (cy[NS] == ref_w[W])
      else $error("R7 carry-out mismatch");
    for (int k = 0; k < NS; k++) begin
      a_r4_skip_passes: assert (!sp[k] || (cy[k+1] == cy[k]))
        else $error("R4 skip carry mismatch in stage %0d", k);
      a_r6_prop_no_gen: assert (!sp[k] || !sg[k])
        else $error("R6 generate with full propagate in stage %0d", k);
    end
    for (int k = 1; k < NS; k++) begin
      a_r2_stage_carry: assert (cy[k] == (ref_w[OFF[k]] ^ a_i[OFF[k]] ^ b_i[OFF[k]]))
        else $error("R2 carry into stage %0d wrong", k);
    end
  end
endmodule

// File: tb/hvs_skip_adder_tb_top.sv
module hvs_skip_adder_tb_top;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [W-1:0] a, b, s;
  logic         ci, co;

  hvs_skip_adder dut_i (.a_i(a), .b_i(b), .cin_i(ci), .sum_o(s), .cout_o(co));

  typedef struct {
    logic [W-1:0] es;
    logic         eco;
    string        tag;
  } item_t;

  item_t q[$];
  int    n_run = 0;
  int    n_fail = 0;
  bit    done = 1'b0;

  task automatic drive(input logic [W-1:0] av, input logic [W-1:0] bv,
                       input logic cv, input string tag);
    item_t it;
    logic [W:0] r;
    @(posedge clk);
    a = av; b = bv; ci = cv;
    r = {1'b0, av} + {1'b0, bv} + {{W{1'b0}}, cv};
    it.es = r[W-1:0]; it.eco = r[W]; it.tag = tag;
    q.push_back(it);
  endtask

  always @(negedge clk) begin
    if (rst_n && q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      n_run++;
      if (s !== it.es || co !== it.eco) begin
        n_fail++;
        $display("FAIL %s: got sum=%h cout=%b expected sum=%h cout=%b",
                 it.tag, s, co, it.es, it.eco);
      end
    end
  end

  initial begin
    a = '0; b = '0; ci = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    drive(32'h0, 32'h0, 1'b0, "R1 idle zero");
    drive(32'h0, 32'h0, 1'b1, "R3 carry-in only");
    drive(32'h7, 32'h1, 1'b0, "R2 stage0 carry into stage1");
    drive(32'h6, 32'h1, 1'b1, "R3 stage0 ripple with cin");
    drive(32'hFF, 32'h1, 1'b0, "R5 increment stage1 overflow");
    drive(32'h1F000000, 32'h0, 1'b0, "R5 partial ones no carry");
    drive(32'h00FFFFF8, 32'h8, 1'b0, "R6 carry entering nucleus");
    drive(32'h00008000, 32'h00008000, 1'b0, "R6 nucleus internal generate");
    drive(32'h0000FF00, 32'h00000100, 1'b0, "R6 nucleus prefix chain");
    drive(32'hFFFFFFFF, 32'h0, 1'b1, "R4 full propagate chain");
    drive(32'hAAAAAAAA, 32'h55555555, 1'b1, "R4 alternating propagate cin1");
    drive(32'hAAAAAAAA, 32'h55555555, 1'b0, "R4 alternating propagate cin0");
    drive(32'hAAAAAAAA, 32'hAAAAAAAA, 1'b0, "R1 alternating generate");
    drive(32'hFFFFFFFF, 32'h1, 1'b0, "R7 all-ones plus one");
    drive(32'hE0000000, 32'h20000000, 1'b0, "R7 top stage carry-out");
    drive(32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1, "R7 max operands");
    drive(32'h1FFFFFF8, 32'h8, 1'b0, "R2 carry through stages 1-3");
    for (int i = 0; i < 400; i++) begin
      drive($urandom, $urandom, 1'($urandom), "R1 random");
    end
    @(posedge clk);
    while (q.size() > 0) @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule